// File: doc/BRIEF.md
# MicroWire Serial Master Controller

This block is a register-mapped master for a three-wire MicroWire-style serial link with four slave selects. Software drives it through a narrow 16-bit register port: it loads an outgoing word, programs a per-slave mode, and then issues a start through the control word. Each start moves a single word of 1 to 16 bits. The word goes either out of the master or into it, never both ways at once.

The serial clock comes from the core clock through two divider stages. The first stage is a global prescaler of 1, 2, 4 or 8. The second is a divider of 2, 4 or 8 that each slave select sets for itself. Each slave select also has its own settings for the data-launch edge, the data-capture edge, the select polarity and an optional ready handshake. The clock idle level is a single global setting. Outgoing words are left-aligned, so they leave the master starting from bit 15. Incoming bits enter at bit 0, so the last bit received is the least significant bit.

Register index map: 0 is data (a write loads the transmit word, a read returns the receive word), 1 is control/status, 2 is clock setup, 3 is clock idle level, and 4 to 7 hold the modes of slave selects 0 to 3.

Top module: `mw_master`

## Requirements
- R1: After reset the control/status word reads 0, `sclk` is 0, and every `cs_out` bit is 1, because all selects are inactive and active-low.
- R2: A start whose write count n is nonzero and whose read count is zero sends bits 15 down to 16-n of the transmit word on `sdo`. The transfer makes exactly 2n clock edges and leaves `sclk` at its idle level.
- R3: A start whose read count n is nonzero and whose write count is zero captures n bits from `sdi`. The last bit lands in bit 0 and the unused upper bits read 0. Status bit 15 (read data ready) sets on the same edge on which busy clears.
- R4: A bit count above 16 is treated as 16. A start in which both counts are zero, or both are nonzero, is ignored: busy stays 0 and no clock edge is made.
- R5: Busy (status bit 14) reads 1 from the cycle after an accepted start until the word completes. A start written while busy is ignored, and so is a transmit-register write made while busy.
- R6: Reading the data register (index 0) clears read data ready.
- R7: In the mode register, bit 0 = 1 captures read data on the falling `sclk` edge and bit 0 = 0 on the rising edge. Bit 1 = 1 launches write data on the rising edge and bit 1 = 0 on the falling edge.
- R8: Bit 0 of the idle-level register (index 3) gives the level `sclk` holds whenever no word is in flight.
- R9: Clock setup (index 2) holds a prescaler select in bits 2:1 and mode bits 4:3 hold a divider code. The `sclk` half period is 2^prescaler × 2^code core cycles, and code 3 acts as code 2.
- R10: Clock setup bit 0 is the module enable. While it is 0, starts are ignored.
- R11: A control write made while idle, with bit 12 set, asserts the select chosen by bits 11:10 and releases the others. The same write with bit 12 clear releases all selects. The selection persists across starts. Mode bit 2 sets a select active-high; otherwise it is active-low.
- R12: A release written while busy takes effect on the edge on which the word completes, not before.
- R13: With mode bit 5 set, an accepted start holds busy and makes no clock edge while `sdi` is 0, and begins shifting once `sdi` is 1.
- R14: Control/status reads as {ready, busy, 0, select asserted, select index[1:0], write count[4:0], read count[4:0]}, with the counts as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_idx | input | 3 | Register index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_idx` |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data to slaves |
| sdi | input | 1 | Serial data from slaves |
| cs_out | output | 4 | Slave selects, each at its own polarity |

## Verification
The hardest states to reach are the ones where software acts in the middle of a word: a second start or a select release arriving while busy, and a start that stalls on the ready handshake. To reach them, the stimulus slows the serial clock with the prescaler, so that a word takes tens of cycles and register writes can land while it is in flight. A bench override holds `sdi` low to keep the handshake stalled for a measured stretch. A behavioural slave counts edges and captures or supplies bits according to the programmed edge modes. Around these cases, a sweep covers every select, edge combination, idle level and bit count for both directions.

// File: rtl/mw_pkg.sv
package mw_pkg;
    localparam int DATA_W    = 16;
    localparam int CS_N      = 4;
    localparam int CNT_W     = 5;
    localparam int PRE_W     = 2;
    localparam int SEL_W     = 2;
    localparam int MODE_W    = 6;

    localparam int IDX_DATA  = 0;
    localparam int IDX_CTRL  = 1;
    localparam int IDX_CLK   = 2;
    localparam int IDX_IDLE  = 3;
    localparam int IDX_MODE0 = 4;

    // control/status word; the field positions are software visible
    typedef struct packed {
        logic             rdy;
        logic             busy;
        logic             start;
        logic             cs_cmd;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] wr_n;
        logic [CNT_W-1:0] rd_n;
    } ctrl_word_t;

    // per-select mode
    typedef struct packed {
        logic       chk_rdy;
        logic [1:0] div;
        logic       cs_high;
        logic       wr_rise;
        logic       rd_fall;
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SHIFT,
        ST_FINISH
    } eng_state_t;

    function automatic int sat_bits(input int c, input int maxv);
        return (c > maxv) ? maxv : c;
    endfunction

    function automatic int half_len(input int pre, input int div);
        int sh;
        sh = (div > 2) ? 2 : div;
        return (1 << pre) << sh;
    endfunction
endpackage

// File: rtl/mw_timebase.sv
module mw_timebase
    import mw_pkg::*;
#(
    parameter int PRE_W  = mw_pkg::PRE_W,
    localparam int HALF_W = (1 << PRE_W) + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PRE_W-1:0] pre_sel,
    input  logic [1:0]       div_sel,
    output logic             tick
);
    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] limit;

    assign limit = HALF_W'(half_len(int'(pre_sel), int'(div_sel)) - 1);
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mw_engine.sv
module mw_engine
    import mw_pkg::*;
#(
    parameter int DATA_W = mw_pkg::DATA_W,
    parameter int CNT_W  = mw_pkg::CNT_W,
    localparam int TOG_W = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              go_write,
    input  logic [CNT_W-1:0]  go_bits,
    input  mode_t             go_mode,
    input  logic              idle_lvl,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              sdi,
    input  logic              tick,
    output logic              run,
    output logic              waiting,
    output logic [1:0]        cur_div,
    output logic              sclk,
    output logic              sdo,
    output logic              done,
    output logic              done_rd,
    output logic [DATA_W-1:0] rx_word
);
    eng_state_t        state_q;
    mode_t             mode_q;
    logic              write_q;
    logic [CNT_W-1:0]  bits_q;
    logic [TOG_W-1:0]  tog_q;
    logic [TOG_W-1:0]  last_tog;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic              sclk_q;
    logic              sdo_q;
    logic              seen_q;
    logic              rising;
    logic              samp_edge;
    logic              drv_edge;

    assign last_tog  = {bits_q, 1'b0} - 1'b1;
    assign rising    = ~sclk_q;
    assign samp_edge = (rising == ~mode_q.rd_fall);
    assign drv_edge  = (rising == mode_q.wr_rise);

    assign run     = (state_q == ST_SHIFT);
    assign waiting = (state_q == ST_WAIT);
    assign done    = (state_q == ST_FINISH);
    assign done_rd = done && !write_q;
    assign cur_div = mode_q.div;
    assign sclk    = sclk_q;
    assign sdo     = sdo_q;
    assign rx_word = rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
            write_q <= 1'b0;
            bits_q  <= '0;
            tog_q   <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
            sclk_q  <= 1'b0;
            sdo_q   <= 1'b0;
            seen_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    sclk_q <= idle_lvl;
                    if (go) begin
                        mode_q  <= go_mode;
                        write_q <= go_write;
                        bits_q  <= go_bits;
                        tog_q   <= '0;
                        tx_q    <= tx_word;
                        sdo_q   <= go_write ? tx_word[DATA_W-1] : 1'b0;
                        rx_q    <= '0;
                        seen_q  <= 1'b0;
                        state_q <= go_mode.chk_rdy ? ST_WAIT : ST_SHIFT;
                    end
                end
                ST_WAIT: begin
                    if (sdi) begin
                        state_q <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        sclk_q <= ~sclk_q;
                        tog_q  <= tog_q + 1'b1;
                        if (!write_q && samp_edge) begin
                            rx_q <= {rx_q[DATA_W-2:0], sdi};
                        end
                        if (write_q) begin
                            if (drv_edge) begin
                                if (seen_q) begin
                                    tx_q  <= tx_q << 1;
                                    sdo_q <= tx_q[DATA_W-2];
                                end
                            end else begin
                                seen_q <= 1'b1;
                            end
                        end
                        if (tog_q == last_tog) begin
                            state_q <= ST_FINISH;
                        end
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/mw_regs.sv
module mw_regs
    import mw_pkg::*;
#(
    parameter int DATA_W = mw_pkg::DATA_W,
    parameter int CS_N   = mw_pkg::CS_N,
    parameter int CNT_W  = mw_pkg::CNT_W,
    parameter int PRE_W  = mw_pkg::PRE_W,
    localparam int SEL_W = $clog2(CS_N),
    localparam int IDX_W = $clog2(IDX_MODE0 + CS_N)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IDX_W-1:0]      reg_idx,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic                  eng_done,
    input  logic                  eng_done_rd,
    input  logic [DATA_W-1:0]     eng_rx,
    output logic                  go,
    output logic                  go_write,
    output logic [CNT_W-1:0]      go_bits,
    output mode_t                 go_mode,
    output logic [DATA_W-1:0]     tx_word,
    output logic                  idle_lvl,
    output logic [PRE_W-1:0]      pre_sel,
    output logic                  busy,
    output logic                  rdy,
    output logic                  cs_on,
    output logic [SEL_W-1:0]      cs_sel,
    output mode_t [CS_N-1:0]      modes
);
    ctrl_word_t        cw;
    logic              ctrl_wr;
    logic              has_wr;
    logic              has_rd;
    logic              en_q;
    logic              busy_q;
    logic              rdy_q;
    logic              cs_on_q;
    logic              pend_off_q;
    logic [SEL_W-1:0]  sel_q;
    logic [CNT_W-1:0]  wr_n_q;
    logic [CNT_W-1:0]  rd_n_q;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic              idle_q;
    logic [PRE_W-1:0]  pre_q;
    mode_t [CS_N-1:0]  modes_q;
    ctrl_word_t        status;

    assign cw       = ctrl_word_t'(reg_wdata);
    assign ctrl_wr  = reg_wr && (reg_idx == IDX_W'(IDX_CTRL));
    assign has_wr   = (cw.wr_n != '0);
    assign has_rd   = (cw.rd_n != '0);
    assign go       = ctrl_wr && !busy_q && cw.start && en_q && (has_wr ^ has_rd);
    assign go_write = has_wr;
    assign go_bits  = CNT_W'(sat_bits(int'(has_wr ? cw.wr_n : cw.rd_n), DATA_W));
    assign go_mode  = modes_q[cw.sel];

    assign tx_word  = tx_q;
    assign idle_lvl = idle_q;
    assign pre_sel  = pre_q;
    assign busy     = busy_q;
    assign rdy      = rdy_q;
    assign cs_on    = cs_on_q;
    assign cs_sel   = sel_q;
    assign modes    = modes_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= 1'b0;
            busy_q     <= 1'b0;
            rdy_q      <= 1'b0;
            cs_on_q    <= 1'b0;
            pend_off_q <= 1'b0;
            sel_q      <= '0;
            wr_n_q     <= '0;
            rd_n_q     <= '0;
            tx_q       <= '0;
            rx_q       <= '0;
            idle_q     <= 1'b0;
            pre_q      <= '0;
        end else begin
            if (reg_wr && reg_idx == IDX_W'(IDX_DATA) && !busy_q) begin
                tx_q <= reg_wdata;
            end
            if (reg_wr && reg_idx == IDX_W'(IDX_CLK)) begin
                en_q  <= reg_wdata[0];
                pre_q <= reg_wdata[PRE_W:1];
            end
            if (reg_wr && reg_idx == IDX_W'(IDX_IDLE)) begin
                idle_q <= reg_wdata[0];
            end
            if (ctrl_wr) begin
                if (!busy_q) begin
                    sel_q   <= cw.sel;
                    cs_on_q <= cw.cs_cmd;
                    wr_n_q  <= cw.wr_n;
                    rd_n_q  <= cw.rd_n;
                end else if (!cw.cs_cmd) begin
                    pend_off_q <= 1'b1;
                end
            end
            if (go) begin
                busy_q <= 1'b1;
            end else if (eng_done) begin
                busy_q <= 1'b0;
                if (pend_off_q) begin
                    cs_on_q    <= 1'b0;
                    pend_off_q <= 1'b0;
                end
            end
            if (eng_done_rd) begin
                rx_q  <= eng_rx;
                rdy_q <= 1'b1;
            end else if (reg_rd && reg_idx == IDX_W'(IDX_DATA)) begin
                rdy_q <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < CS_N; g++) begin : g_mode
        always_ff @(posedge clk) begin
            if (rst) begin
                modes_q[g] <= '0;
            end else if (reg_wr && reg_idx == IDX_W'(IDX_MODE0 + g)) begin
                modes_q[g] <= mode_t'(reg_wdata[MODE_W-1:0]);
            end
        end
    end

    always_comb begin
        status        = '0;
        status.rdy    = rdy_q;
        status.busy   = busy_q;
        status.cs_cmd = cs_on_q;
        status.sel    = sel_q;
        status.wr_n   = wr_n_q;
        status.rd_n   = rd_n_q;
        reg_rdata     = '0;
        case (int'(reg_idx))
            IDX_DATA: reg_rdata = rx_q;
            IDX_CTRL: reg_rdata = status;
            IDX_CLK:  reg_rdata = DATA_W'({pre_q, en_q});
            IDX_IDLE: reg_rdata = DATA_W'(idle_q);
            default: begin
                for (int i = 0; i < CS_N; i++) begin
                    if (int'(reg_idx) == IDX_MODE0 + i) begin
                        reg_rdata = DATA_W'(modes_q[i]);
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/mw_master.sv
module mw_master
    import mw_pkg::*;
#(
    parameter int DATA_W = mw_pkg::DATA_W,
    parameter int CS_N   = mw_pkg::CS_N,
    parameter int CNT_W  = mw_pkg::CNT_W,
    parameter int PRE_W  = mw_pkg::PRE_W,
    localparam int SEL_W = $clog2(CS_N),
    localparam int IDX_W = $clog2(IDX_MODE0 + CS_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sclk,
    output logic              sdo,
    input  logic              sdi,
    output logic [CS_N-1:0]   cs_out
);
    logic              go;
    logic              go_write;
    logic [CNT_W-1:0]  go_bits;
    mode_t             go_mode;
    logic [DATA_W-1:0] tx_word;
    logic              idle_lvl;
    logic [PRE_W-1:0]  pre_sel;
    logic              busy;
    logic              rdy;
    logic              cs_on;
    logic [SEL_W-1:0]  cs_sel;
    mode_t [CS_N-1:0]  modes;
    logic              run;
    logic              waiting;
    logic [1:0]        cur_div;
    logic              tick;
    logic              done;
    logic              done_rd;
    logic [DATA_W-1:0] rx_word;
    logic [CS_N-1:0]   cs_act;

    mw_regs #(
        .DATA_W(DATA_W), .CS_N(CS_N), .CNT_W(CNT_W), .PRE_W(PRE_W)
    ) u_regs (
        .clk(clk), .rst(rst),
        .reg_idx(reg_idx), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_done(done), .eng_done_rd(done_rd), .eng_rx(rx_word),
        .go(go), .go_write(go_write), .go_bits(go_bits), .go_mode(go_mode),
        .tx_word(tx_word), .idle_lvl(idle_lvl), .pre_sel(pre_sel),
        .busy(busy), .rdy(rdy), .cs_on(cs_on), .cs_sel(cs_sel), .modes(modes)
    );

    mw_timebase #(.PRE_W(PRE_W)) u_tb (
        .clk(clk), .rst(rst), .run(run),
        .pre_sel(pre_sel), .div_sel(cur_div), .tick(tick)
    );

    mw_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst(rst),
        .go(go), .go_write(go_write), .go_bits(go_bits), .go_mode(go_mode),
        .idle_lvl(idle_lvl), .tx_word(tx_word), .sdi(sdi), .tick(tick),
        .run(run), .waiting(waiting), .cur_div(cur_div),
        .sclk(sclk), .sdo(sdo), .done(done), .done_rd(done_rd), .rx_word(rx_word)
    );

    for (genvar g = 0; g < CS_N; g++) begin : g_cs
        assign cs_act[g] = cs_on && (cs_sel == SEL_W'(g));
        assign cs_out[g] = ~cs_act[g] ^ modes[g].cs_high;
    end
endmodule

// File: rtl/mw_master_chk.sv
module mw_master_chk #(
    parameter int CS_N = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            go,
    input logic            busy,
    input logic            rdy,
    input logic            cs_on,
    input logic [CS_N-1:0] cs_act,
    input logic            sclk,
    input logic            idle_lvl,
    input logic            waiting
);
    AST_GO_BUSY: assert property (@(posedge clk) disable iff (rst)
        go |=> busy); // R5

    AST_RDY_AT_END: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> $fell(busy)); // R3

    AST_CS_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cs_on)); // R12

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> (sclk == $past(idle_lvl))); // R8

    AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        waiting |=> $stable(sclk)); // R13

    AST_CS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        !cs_on |-> (cs_act == '0)); // R11
endmodule

bind mw_master mw_master_chk #(.CS_N(CS_N)) u_chk (
    .clk(clk), .rst(rst), .go(go), .busy(busy), .rdy(rdy),
    .cs_on(cs_on), .cs_act(cs_act), .sclk(sclk), .idle_lvl(idle_lvl),
    .waiting(waiting)
);

// File: tb/test_mw_master.sv
module test_mw_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_idx = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        sclk;
    logic        sdo;
    logic        sdi;
    logic [3:0]  cs_out;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    mw_master i_mw_master (
        .clk(clk), .rst(rst), .reg_idx(reg_idx), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .sdo(sdo), .sdi(sdi), .cs_out(cs_out)
    );

    // behavioural slave
    logic        slv_act = 1'b0;
    logic        slv_wr_rise = 1'b0;
    logic        slv_rd_fall = 1'b0;
    logic        hold_low = 1'b0;
    int          slv_n = 1;
    logic [15:0] slv_word = '0;
    logic [15:0] cap = '0;
    int          sidx = 0;
    int          tog = 0;
    time         tog_t [0:7];
    logic [3:0]  bpol = '0;

    always @(sclk) begin
        if (slv_act) begin
            if (tog < 8) tog_t[tog] = $time;
            tog = tog + 1;
            if (sclk != slv_wr_rise) cap = {cap[14:0], sdo};
            if (sclk != slv_rd_fall) sidx = sidx + 1;
        end
    end

    always @* begin
        if (hold_low) sdi = 1'b0;
        else if (sidx < slv_n) sdi = slv_word[slv_n-1-sidx];
        else sdi = 1'b0;
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [15:0] d);
        reg_idx = idx[2:0];
        reg_wdata = d;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [15:0] d, input bit strobe);
        reg_idx = idx[2:0];
        #1;
        d = reg_rdata;
        reg_rd = strobe;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle(output logic [15:0] st);
        int guard = 0;
        rd(1, st, 1'b0);
        while (st[14] && guard < 3000) begin
            rd(1, st, 1'b0);
            guard++;
        end
    endtask

    task automatic cs_expect(input int sel, input bit on, input string req);
        for (int i = 0; i < 4; i++) begin
            logic act;
            act = on && (i == sel);
            check(req, {31'd0, cs_out[i]}, {31'd0, act ? bpol[i] : ~bpol[i]});
        end
    endtask

    task automatic arm_slave(input logic [5:0] mode, input int n, input logic [15:0] w);
        @(negedge clk);
        slv_n = n; slv_word = w; sidx = 0; cap = '0; tog = 0;
        slv_wr_rise = mode[1]; slv_rd_fall = mode[0];
        slv_act = 1'b1;
    endtask

    task automatic xfer(input int cs, input logic [5:0] mode, input bit cp,
                        input bit is_wr, input int nraw, input logic [15:0] data);
        int n;
        logic [15:0] st;
        logic [15:0] got;
        logic [31:0] mask;
        n = (nraw > 16) ? 16 : nraw;
        mask = (32'd1 << n) - 1;
        wr(4 + cs, {10'd0, mode});
        bpol[cs] = mode[2];
        wr(3, {15'd0, cp});
        arm_slave(mode, n, data);
        if (is_wr) wr(0, data);
        wr(1, 16'h3000 | 16'(cs << 10) | (is_wr ? 16'(nraw << 5) : 16'(nraw)));
        rd(1, st, 1'b0);
        check("R5 busy after start", {31'd0, st[14]}, 32'd1);
        wait_idle(st);
        slv_act = 1'b0;
        check("R2/R3/R4 edge count", tog, 2 * n);
        check("R8 idle level after word", {31'd0, sclk}, {31'd0, cp});
        cs_expect(cs, 1'b1, "R11 select persists");
        if (is_wr) begin
            check("R2/R7 written bits", {16'd0, cap} & mask, {16'd0, data >> (16 - n)});
        end else begin
            check("R3 ready set", {31'd0, st[15]}, 32'd1);
            rd(0, got, 1'b1);
            check("R3/R7 received word", {16'd0, got}, {16'd0, data} & mask);
            rd(1, st, 1'b0);
            check("R6 ready cleared", {31'd0, st[15]}, 32'd0);
        end
    endtask

    initial begin
        #(4 * 190000);
        fails++;
        $display("FAIL watchdog got=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] st;
        int k;
        int nlist [4];
        nlist = '{1, 7, 16, 21};
        k = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(1, st, 1'b0);
        check("R1 status", {16'd0, st}, 32'd0);
        check("R1 sclk", {31'd0, sclk}, 32'd0);
        check("R1 selects", {28'd0, cs_out}, 32'hF);

        // R14 status layout, R11 assert / release
        wr(2, 16'h0001);
        wr(1, 16'h1000 | (16'd2 << 10) | (16'd9 << 5));
        rd(1, st, 1'b0);
        check("R14 status fields", {16'd0, st}, 32'h1000 | (2 << 10) | (9 << 5));
        cs_expect(2, 1'b1, "R11 assert");
        wr(1, 16'd2 << 10);
        cs_expect(2, 1'b0, "R11 release");

        // main sweep: R2 R3 R4 R7 R8 R11
        for (int cs = 0; cs < 4; cs++)
            for (int e = 0; e < 4; e++)
                for (int cp = 0; cp < 2; cp++)
                    for (int ni = 0; ni < 4; ni++)
                        for (int dir = 0; dir < 2; dir++) begin
                            logic [5:0] mode;
                            mode = {3'b000, 1'(e ^ cs), 2'(e)};
                            xfer(cs, mode, cp[0], dir[0], nlist[ni], 16'hA5C3 ^ 16'(k * 16'h1357));
                            k++;
                        end

        // R9 divider sweep
        for (int p = 0; p < 4; p++)
            for (int d = 0; d < 4; d++) begin
                int exp_half;
                wr(2, 16'h0001 | 16'(p << 1));
                xfer(0, {1'b0, 2'(d), 3'b000}, 1'b0, 1'b1, 2, 16'hC000);
                exp_half = (1 << p) << ((d == 3) ? 2 : d);
                check("R9 half period", 32'((tog_t[1] - tog_t[0]) / 4), exp_half);
            end

        // R4 both counts / no counts
        wr(2, 16'h0001);
        arm_slave(6'd0, 4, 16'h0);
        wr(1, 16'h3000 | (16'd3 << 5) | 16'd3);
        rd(1, st, 1'b0);
        check("R4 both counts ignored", {31'd0, st[14]}, 32'd0);
        wr(1, 16'h3000);
        rd(1, st, 1'b0);
        check("R4 zero counts ignored", {31'd0, st[14]}, 32'd0);
        repeat (10) @(negedge clk);
        check("R4 no edges", tog, 0);

        // R10 enable clear
        wr(2, 16'h0000);
        wr(1, 16'h3000 | (16'd4 << 5));
        rd(1, st, 1'b0);
        check("R10 start ignored when disabled", {31'd0, st[14]}, 32'd0);
        repeat (10) @(negedge clk);
        check("R10 no edges", tog, 0);
        slv_act = 1'b0;

        // R5 start and tx write ignored while busy
        wr(2, 16'h0005);
        wr(4, 16'h0000);
        bpol[0] = 1'b0;
        wr(3, 16'h0000);
        arm_slave(6'd0, 8, 16'h0);
        wr(0, 16'h9600);
        wr(1, 16'h3000 | (16'd8 << 5));
        repeat (6) @(negedge clk);
        wr(0, 16'h0FF0);
        wr(1, 16'h3000 | (16'd12 << 5));
        wait_idle(st);
        check("R5 second start ignored", tog, 16);
        check("R5 first word kept", {24'd0, cap[7:0]}, 32'h96);
        check("R14 counts kept while busy", {27'd0, st[9:5]}, 32'd8);
        repeat (10) @(negedge clk);
        rd(1, st, 1'b0);
        check("R5 no queued start", {31'd0, st[14]}, 32'd0);
        slv_act = 1'b0;

        // R12 release while busy
        arm_slave(6'd0, 8, 16'h0);
        wr(0, 16'h5A00);
        wr(1, 16'h3000 | (16'd8 << 5));
        repeat (6) @(negedge clk);
        wr(1, 16'h0000);
        cs_expect(0, 1'b1, "R12 held during word");
        wait_idle(st);
        cs_expect(0, 1'b0, "R12 released at end");
        slv_act = 1'b0;

        // R13 ready handshake
        wr(2, 16'h0001);
        wr(4, 16'h0020);
        arm_slave(6'h20, 4, 16'hFFFF);
        hold_low = 1'b1;
        wr(0, 16'hB000);
        wr(1, 16'h3000 | (16'd4 << 5));
        repeat (20) @(negedge clk);
        rd(1, st, 1'b0);
        check("R13 busy while waiting", {31'd0, st[14]}, 32'd1);
        check("R13 no edges while waiting", tog, 0);
        hold_low = 1'b0;
        wait_idle(st);
        check("R13 edges after ready", tog, 8);
        check("R13 word sent", {28'd0, cap[3:0]}, 32'hB);
        slv_act = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule